// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches a set of external interrupt pins, eight by default, that arrive asynchronously to the core clock. Each pin first passes through a two-stage synchroniser. It then goes through a sense stage that can be set to one of four modes: active-low level, falling edge, rising edge, or any edge. For each pin the block keeps one status bit. It drives that bit out as an active-high request line to an upstream interrupt controller, whatever sense mode is chosen.

Software uses a plain word-wide register port with an address, a write strobe, write data and registered read data. It has two registers. The sense register holds a 2-bit mode field per pin. The status register shows the per-pin status bits. Writing a zero to a status bit acknowledges it, but only for pins in an edge mode. A level-mode bit simply mirrors the synchronised pin.

Top module: `ext_pin_sense`

## Requirements
- R1: After reset every status bit and every request is 0, and the sense register reads 0 (all pins in low-level mode), with pins held high.
- R2: The sense register sits at byte address 0x14. Pin n's mode is bits [2n+1:2n], encoded 0 = low level, 1 = falling edge, 2 = rising edge, 3 = any edge. Bits above the last field read as 0. Read data shows up one clock after the address is presented.
- R3: In low-level mode (0), a pin's request is 1 exactly while the synchronised pin is low. The request rises three clock edges after the pin falls. Writing 0 to that status bit has no effect.
- R4: In falling-edge mode (1), a high-to-low transition sets the status bit, and a low-to-high transition does not.
- R5: In rising-edge mode (2), a low-to-high transition sets the status bit, and a high-to-low transition does not.
- R6: In any-edge mode (3), both transition directions set the status bit.
- R7: A write to the status register at byte address 0x10 clears bit n of an edge-mode pin when write-data bit n is 0. Writing 1 leaves the bit unchanged.
- R8: If a detected edge and a clearing write hit the same pin in the same cycle, the bit ends up set.
- R9: Request n equals status bit n, and the status register reads the status bits at bits [n], with the upper bits 0.
- R10: In an edge mode a set status bit stays set after the pin returns to its idle level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous external interrupt pins |
| addr_i | input | AW | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the address |
| req_o | output | NPINS | Active-high level requests to the upstream controller |

## Verification
The assertions assume that pins change no faster than the synchroniser can follow and that the register address is stable across the cycle it is sampled. The bench drives every input on the falling clock edge. It holds each pin level for at least three cycles before checking, and it times the same-cycle edge-and-clear case by counting rising edges from the pin transition. Pins are held high through reset, which matches the synchroniser's idle-high reset value, so no false edge is seen at start-up.

// File: rtl/pinsense_pkg.sv
package pinsense_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'd0,
        SNS_FALL = 2'd1,
        SNS_RISE = 2'd2,
        SNS_BOTH = 2'd3
    } sense_t;

    localparam int REG_W = 32;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] smp_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] smp;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.smp  = st_q.meta;
        st_d.prev = st_q.smp;
    end

    // Idle-high reset so that pins parked high raise no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{meta: '1, smp: '1, prev: '1};
        else        st_q <= st_d;
    end

    assign smp_o  = st_q.smp;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pinsense_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_t mode_i,
    input  logic   smp_i,
    input  logic   prev_i,
    input  logic   clr_i,
    output logic   st_o
);

    typedef struct packed {
        logic flag;
    } evt_t;

    evt_t st_d, st_q;
    logic fall_w, rise_w, hit_w;

    always_comb begin
        fall_w = prev_i & ~smp_i;
        rise_w = ~prev_i & smp_i;
        unique case (mode_i)
            SNS_FALL: hit_w = fall_w;
            SNS_RISE: hit_w = rise_w;
            SNS_BOTH: hit_w = fall_w | rise_w;
            default:  hit_w = 1'b0;
        endcase
        st_d = st_q;
        if (mode_i == SNS_LOW)  st_d.flag = ~smp_i;
        else if (hit_w)         st_d.flag = 1'b1;
        else if (clr_i)         st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{flag: 1'b0};
        else        st_q <= st_d;
    end

    assign st_o = st_q.flag;

    // R3: low-level mode mirrors the inverted sample, clearing ignored
    a_r3_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SNS_LOW) |=> (st_o == !$past(smp_i)));

    // R8: an edge wins over a same-cycle clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SNS_LOW && hit_w) |=> st_o);

    // R7: a clear without an edge drops the bit
    a_r7_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SNS_LOW && clr_i && !hit_w) |=> !st_o);

    // R10: with no edge and no clear an edge-mode bit holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SNS_LOW && !clr_i && !hit_w) |=> $stable(st_o));

endmodule

// File: rtl/ext_pin_sense.sv
module ext_pin_sense
    import pinsense_pkg::*;
#(
    parameter int          NPINS     = 8,
    parameter int          AW        = 8,
    parameter logic [7:0]  STAT_ADDR = 8'h10,
    parameter logic [7:0]  CFG_ADDR  = 8'h14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     pin_i,
    input  logic [AW-1:0]        addr_i,
    input  logic                 wr_en_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic [NPINS-1:0]     req_o
);

    localparam int CFG_W = 2 * NPINS;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [NPINS-1:0] smp_w, prev_w, clr_w, stat_w;
    logic             stat_sel, cfg_sel;
    logic             unused_wbits;

    assign stat_sel     = (addr_i == AW'(STAT_ADDR));
    assign cfg_sel      = (addr_i == AW'(CFG_ADDR));
    assign unused_wbits = ^wdata_i[REG_W-1:CFG_W];

    pin_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .smp_o  (smp_w),
        .prev_o (prev_w)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign clr_w[i] = wr_en_i & stat_sel & ~wdata_i[i];
        pin_event_unit u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (sense_t'(rg_q.cfg[2*i +: 2])),
            .smp_i  (smp_w[i]),
            .prev_i (prev_w[i]),
            .clr_i  (clr_w[i]),
            .st_o   (stat_w[i])
        );
    end

    always_comb begin
        rg_d       = rg_q;
        rg_d.rdata = '0;
        if (wr_en_i && cfg_sel) rg_d.cfg = wdata_i[CFG_W-1:0];
        if (stat_sel)           rg_d.rdata[NPINS-1:0] = stat_w;
        else if (cfg_sel)       rg_d.rdata[CFG_W-1:0] = rg_q.cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '{cfg: '0, rdata: '0};
        else        rg_q <= rg_d;
    end

    assign rdata_o = rg_q.rdata;
    assign req_o   = stat_w;

    // R2: sense register contents come back one cycle after the address
    a_r2_cfg_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_sel) |-> (rdata_o == REG_W'($past(rg_q.cfg))));

    // R9: status readback agrees with the request lines
    a_r9_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_sel) |-> (rdata_o == REG_W'($past(req_o))));

endmodule

// File: tb/sim_ext_pin_sense.sv
module sim_ext_pin_sense;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = 8'hFF;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ext_pin_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .addr_i(addr),
        .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata), .req_o(req)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a; wr = 1'b0;
        tick(1);
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk({24'd0, req}, 32'h0, "R1 req after reset");
        rd_reg(8'h14, v); chk(v, 32'h0, "R1 sense reg after reset");
        rd_reg(8'h10, v); chk(v, 32'h0, "R1 status after reset");
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr_reg(8'h14, 32'hABCD_1B6C);
        rd_reg(8'h14, v); chk(v, 32'h0000_1B6C, "R2 sense readback");
        wr_reg(8'h14, 32'h0);
        rd_reg(8'h14, v); chk(v, 32'h0, "R2 sense cleared");
    endtask

    task automatic t_low();
        pin[3] = 1'b0;
        tick(2); chk({24'd0, req}, 32'h0, "R3 latency not yet");
        tick(1); chk({24'd0, req}, 32'h08, "R3 low level asserts");
        wr_reg(8'h10, 32'h0);
        tick(1); chk({24'd0, req}, 32'h08, "R3 clear ignored in level mode");
        pin[3] = 1'b1;
        tick(3); chk({24'd0, req}, 32'h0, "R3 released");
    endtask

    task automatic t_fall();
        wr_reg(8'h14, 32'h5555);
        pin[0] = 1'b0;
        tick(3); chk({24'd0, req}, 32'h01, "R4 falling edge sets");
        pin[0] = 1'b1;
        tick(3); chk({24'd0, req}, 32'h01, "R10 held after pin idle");
        wr_reg(8'h10, 32'h0);
        tick(1); chk({24'd0, req}, 32'h0, "R7 clear edge bit");
        pin = 8'h00;
        tick(3); chk({24'd0, req}, 32'hFF, "R4 all pins fall");
        wr_reg(8'h10, 32'h0);
        pin = 8'hFF;
        tick(3); chk({24'd0, req}, 32'h0, "R4 rising ignored");
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr_reg(8'h14, 32'hAAAA);
        pin[2] = 1'b0;
        tick(3); chk({24'd0, req}, 32'h0, "R5 falling ignored");
        pin[2] = 1'b1;
        tick(3); chk({24'd0, req}, 32'h04, "R5 rising sets");
        wr_reg(8'h10, 32'hFF);
        tick(1); chk({24'd0, req}, 32'h04, "R7 writing one keeps bit");
        rd_reg(8'h10, v); chk(v, 32'h04, "R9 status readback");
        wr_reg(8'h10, 32'h0);
        tick(1); chk({24'd0, req}, 32'h0, "R7 rise bit cleared");
    endtask

    task automatic t_both();
        wr_reg(8'h14, 32'hFFFF);
        pin[5] = 1'b0;
        tick(3); chk({24'd0, req}, 32'h20, "R6 fall sets");
        wr_reg(8'h10, 32'h0);
        pin[5] = 1'b1;
        tick(3); chk({24'd0, req}, 32'h20, "R6 rise sets");
        wr_reg(8'h10, 32'h0);
        tick(1); chk({24'd0, req}, 32'h0, "R6 cleared");
    endtask

    task automatic t_set_wins();
        wr_reg(8'h14, 32'hAAAA);
        pin[6] = 1'b0;
        tick(3); chk({24'd0, req}, 32'h0, "R8 setup no status");
        pin[6] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_reg(8'h10, 32'h0);
        chk({24'd0, req}, 32'h40, "R8 set beats clear");
        wr_reg(8'h10, 32'h0);
        tick(1); chk({24'd0, req}, 32'h0, "R8 later clear works");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_cfg();
        t_low();
        t_fall();
        t_rise();
        t_both();
        t_set_wins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule